// File: doc/BRIEF.md
# Region-based memory wait-state generator

This block sits between a CPU bus that issues one access per cycle with a 24-bit address and the memory and peripheral decoders behind it. For every accepted request it classifies the address into a region, selects a stall length that may differ for reads and writes, and holds the bus not-ready for exactly that many cycles before it signals completion. Alongside the stall it produces the target address after mirror folding, a flag telling the read path to return zero for empty port space, and a fault pulse for writes into the write-protected low half of the map.

Flash latency is a fixed base plus a software-programmable term held in a small configuration register. A second configuration bit opens the upper flash window, so that reads there take flash timing instead of the long unmapped-space stall. The memories, the peripherals and any DMA arbitration are outside this block.

Top module: `memwait_ctrl`

## Requirements
- R1: A read in 0x000000–0x3FFFFF stalls for FLASH_BASE (5) plus the flash extra register (config select 0, reset value 4, so 9 after reset); 0 gives 5 and 255 gives 260.
- R2: A write anywhere in 0x000000–0x7FFFFF causes no stall, no completion and no write strobe. Instead fault_pulse is high for exactly the cycle after acceptance, fault_addr holds the untranslated address and req_ready stays high.
- R3: A read in 0x400000–0x7FFFFF stalls 257 cycles while the window bit (config select 1, bit 0, reset 0) is clear, and takes the R1 flash count while it is set.
- R4: Reads and writes in 0x800000–0xCFFFFF stall 257 cycles.
- R5: In 0xD00000–0xDFFFFF reads stall 3 and writes stall 1. The target address has bit 19 cleared, so 0xD8xxxx–0xDFxxxx folds onto 0xD0xxxx–0xD7xxxx.
- R6: The 64 KiB port windows starting at 0xE00000, 0xE20000 and 0xE30000 stall 1/1, 3/3 and 2 (read) / 1 (write). The first aliases every 0x100 bytes, the second every 0x200 bytes, and the third passes its address through unchanged. Aliasing keeps bits 23:16 plus the low log2(period) bits and zeroes the rest.
- R7: Reads return acc_rd_zero = 1 at completion for 0xE10000–0xE1FFFF (1/1), 0xE40000–0xEFFFFF (1/1), 0xFA0000–0xFEFFFF (2/2) and 0xFF0000–0xFFFFFF (1/1). Writes there and any access elsewhere give 0.
- R8: The ten windows 0xF00000 through 0xF9FFFF stall 2 each way and alias with periods, in window order, of 0x100, 0x20, 0x100, 0x80, 0x1000, 0x80, 0x1000, 0x100, 0x80 and 0x80 bytes.
- R9: A request is accepted when req_valid and req_ready are both high at a clock edge. For a stall of N, req_ready is low for exactly N cycles after that edge. acc_done then pulses for one cycle with req_ready high again, and acc_addr is valid. acc_wr_stb pulses with acc_done only for writes. Requests presented while req_ready is low are ignored.
- R10: The config port writes on cfg_we at a clock edge (cfg_sel 0 = flash extra, 8 bits; cfg_sel 1 = window bit in bit 0). cfg_rdata returns the selected register, with zeros above bit 0 for select 1. A new value applies only to requests accepted at later edges; a request accepted at the same edge uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Access address |
| req_ready | output | 1 | High when a request can be accepted |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_wr_stb | output | 1 | Write strobe to target, with acc_done |
| acc_addr | output | 24 | Translated target address |
| acc_rd_zero | output | 1 | Read data must be forced to zero |
| fault_pulse | output | 1 | One-cycle illegal-write fault |
| fault_addr | output | 24 | Address of the last faulting write |
| cfg_we | input | 1 | Config register write enable |
| cfg_sel | input | 1 | Config register select |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data |

## Verification
The assertions assume that reset is held high from the first edge for at least one cycle. They also assume that a request stays on the bus only while req_ready is high, or that anything presented during a stall may be discarded. The bench drives every request in the cycle where it sees req_ready high and removes it after one edge. The one exception is a deliberate test in which req_valid is held through a stall, to show that it is ignored. Config writes are one-cycle pulses with a defined select, and the one same-edge collision with a request is placed on purpose, to pin down which value applies.

// File: rtl/memwait_pkg.sv
package memwait_pkg;

  localparam int ADDR_W = 24;

  // Where a region's stall length comes from
  typedef enum logic [1:0] {
    WS_FIXED = 2'd0,
    WS_FLASH = 2'd1,
    WS_SLOW  = 2'd2
  } ws_src_e;

  typedef struct packed {
    ws_src_e    src;
    logic [3:0] rd_fix;
    logic [3:0] wr_fix;
    logic       wr_bad;
    logic       rd_zero;
    logic       fold_on;
    logic [3:0] fold_lg;
    logic       ram_mirror;
  } region_t;

  // log2 of alias period for the ten peripheral windows at 0xF0..0xF9
  function automatic logic [3:0] fwin_fold_lg(input logic [3:0] idx);
    case (idx)
      4'd0, 4'd2, 4'd7:        return 4'd8;
      4'd1:                    return 4'd5;
      4'd3, 4'd5, 4'd8, 4'd9:  return 4'd7;
      4'd4, 4'd6:              return 4'd12;
      default:                 return 4'd0;
    endcase
  endfunction

  function automatic region_t region_lookup(input logic [7:0] hi, input logic win_map);
    region_t r;
    r = '{src: WS_FIXED, rd_fix: 4'd1, wr_fix: 4'd1, wr_bad: 1'b0, rd_zero: 1'b0,
          fold_on: 1'b0, fold_lg: 4'd0, ram_mirror: 1'b0};
    if (hi < 8'h40) begin
      r.src    = WS_FLASH;
      r.wr_bad = 1'b1;
    end else if (hi < 8'h80) begin
      r.src    = win_map ? WS_FLASH : WS_SLOW;
      r.wr_bad = 1'b1;
    end else if (hi < 8'hD0) begin
      r.src = WS_SLOW;
    end else if (hi < 8'hE0) begin
      r.rd_fix     = 4'd3;
      r.wr_fix     = 4'd1;
      r.ram_mirror = 1'b1;
    end else if (hi == 8'hE0) begin
      r.fold_on = 1'b1;
      r.fold_lg = 4'd8;
    end else if (hi == 8'hE1) begin
      r.rd_zero = 1'b1;
    end else if (hi == 8'hE2) begin
      r.rd_fix  = 4'd3;
      r.wr_fix  = 4'd3;
      r.fold_on = 1'b1;
      r.fold_lg = 4'd9;
    end else if (hi == 8'hE3) begin
      r.rd_fix = 4'd2;
      r.wr_fix = 4'd1;
    end else if (hi < 8'hF0) begin
      r.rd_zero = 1'b1;
    end else if (hi < 8'hFA) begin
      r.rd_fix  = 4'd2;
      r.wr_fix  = 4'd2;
      r.fold_on = 1'b1;
      r.fold_lg = fwin_fold_lg(hi[3:0]);
    end else if (hi < 8'hFF) begin
      r.rd_fix  = 4'd2;
      r.wr_fix  = 4'd2;
      r.rd_zero = 1'b1;
    end else begin
      r.rd_zero = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/memwait_cfg.sv
module memwait_cfg #(
  parameter int CFG_W     = 8,
  parameter int EXTRA_RST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [CFG_W-1:0] flash_extra,
  output logic             win_map
);

  logic [CFG_W-1:0] extra_q;
  logic             map_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      extra_q <= CFG_W'(EXTRA_RST);
      map_q   <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_sel) map_q   <= cfg_wdata[0];
      else         extra_q <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = cfg_sel ? {{(CFG_W-1){1'b0}}, map_q} : extra_q;
  end

  assign flash_extra = extra_q;
  assign win_map     = map_q;

  // R10: registers only move on a write strobe
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(extra_q) && $stable(map_q)));

endmodule

// File: rtl/memwait_decode.sv
module memwait_decode
  import memwait_pkg::*;
#(
  parameter int WS_W       = 9,
  parameter int CFG_W      = 8,
  parameter int FLASH_BASE = 5,
  parameter int SLOW_WS    = 257
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              win_map,
  input  logic [CFG_W-1:0]  flash_extra,
  output logic [WS_W-1:0]   ws,
  output logic              fault,
  output logic              rd_zero,
  output logic [ADDR_W-1:0] tgt_addr
);

  localparam int LOW_W = 16;

  region_t          reg_info;
  logic [LOW_W-1:0] fold_mask;

  always_comb reg_info = region_lookup(addr[ADDR_W-1:LOW_W], win_map);

  // Build the alias mask bit by bit from the period exponent
  genvar gi;
  generate
    for (gi = 0; gi < LOW_W; gi++) begin : g_mask
      assign fold_mask[gi] = !reg_info.fold_on || (gi < int'(reg_info.fold_lg));
    end
  endgenerate

  always_comb begin
    case (reg_info.src)
      WS_FLASH: ws = WS_W'(FLASH_BASE) + WS_W'(flash_extra);
      WS_SLOW:  ws = WS_W'(SLOW_WS);
      default:  ws = write ? WS_W'(reg_info.wr_fix) : WS_W'(reg_info.rd_fix);
    endcase
    fault   = write && reg_info.wr_bad;
    rd_zero = reg_info.rd_zero;
    tgt_addr = {addr[ADDR_W-1:LOW_W], addr[LOW_W-1:0] & fold_mask};
    if (reg_info.ram_mirror) tgt_addr[19] = 1'b0;
  end

endmodule

// File: rtl/memwait_seq.sv
module memwait_seq #(
  parameter int WS_W   = 9,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WS_W-1:0]   dec_ws,
  input  logic              dec_fault,
  input  logic              dec_zero,
  input  logic [ADDR_W-1:0] dec_addr,
  output logic              ready,
  output logic              done,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              rd_zero,
  output logic              fault,
  output logic [ADDR_W-1:0] fault_addr
);

  logic              ready_q, done_q, wstb_q, wr_q, zero_q, flt_q;
  logic [WS_W-1:0]   cnt_q;
  logic [ADDR_W-1:0] addr_q, faddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b1;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      wstb_q  <= 1'b0;
      wr_q    <= 1'b0;
      zero_q  <= 1'b0;
      flt_q   <= 1'b0;
      addr_q  <= '0;
      faddr_q <= '0;
    end else begin
      done_q <= 1'b0;
      wstb_q <= 1'b0;
      flt_q  <= 1'b0;
      if (ready_q) begin
        if (req_valid) begin
          if (dec_fault) begin
            flt_q   <= 1'b1;
            faddr_q <= req_addr;
          end else begin
            addr_q <= dec_addr;
            wr_q   <= req_write;
            zero_q <= dec_zero && !req_write;
            if (dec_ws == '0) begin
              done_q <= 1'b1;
              wstb_q <= req_write;
            end else begin
              ready_q <= 1'b0;
              cnt_q   <= dec_ws - WS_W'(1);
            end
          end
        end
      end else if (cnt_q == '0) begin
        ready_q <= 1'b1;
        done_q  <= 1'b1;
        wstb_q  <= wr_q;
      end else begin
        cnt_q <= cnt_q - WS_W'(1);
      end
    end
  end

  assign ready      = ready_q;
  assign done       = done_q;
  assign wr_stb     = wstb_q;
  assign acc_addr   = addr_q;
  assign rd_zero    = zero_q;
  assign fault      = flt_q;
  assign fault_addr = faddr_q;

  // R9: completion always coincides with the bus being ready again
  assert_done_ready_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ready_q);
  // R9: ready only returns through a completion
  assert_ready_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> done_q);
  // R9: a stall only starts from a presented request
  assert_stall_start_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_q) |-> $past(req_valid));
  // R9: write strobe only accompanies completion
  assert_wrstb_done_R9: assert property (@(posedge clk) disable iff (rst)
    wstb_q |-> done_q);
  // R9: target address holds while stalled
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!ready_q && $past(!ready_q)) |-> $stable(addr_q));
  // R2: faults come from writes in the low half, never stall or complete
  assert_fault_low_R2: assert property (@(posedge clk) disable iff (rst)
    flt_q |-> (!faddr_q[ADDR_W-1] && $past(req_write) && ready_q && !done_q));
  // R2: the fault is a single-cycle pulse
  assert_fault_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    flt_q |=> !flt_q);

endmodule

// File: rtl/memwait_ctrl.sv
module memwait_ctrl #(
  parameter int WS_W       = 9,
  parameter int CFG_W      = 8,
  parameter int FLASH_BASE = 5,
  parameter int SLOW_WS    = 257,
  parameter int EXTRA_RST  = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic [memwait_pkg::ADDR_W-1:0] req_addr,
  output logic                           req_ready,
  output logic                           acc_done,
  output logic                           acc_wr_stb,
  output logic [memwait_pkg::ADDR_W-1:0] acc_addr,
  output logic                           acc_rd_zero,
  output logic                           fault_pulse,
  output logic [memwait_pkg::ADDR_W-1:0] fault_addr,
  input  logic                           cfg_we,
  input  logic                           cfg_sel,
  input  logic [CFG_W-1:0]               cfg_wdata,
  output logic [CFG_W-1:0]               cfg_rdata
);

  localparam int AW = memwait_pkg::ADDR_W;

  logic [CFG_W-1:0] flash_extra;
  logic             win_map;
  logic [WS_W-1:0]  dec_ws;
  logic             dec_fault, dec_zero;
  logic [AW-1:0]    dec_addr;

  memwait_cfg #(.CFG_W(CFG_W), .EXTRA_RST(EXTRA_RST)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .flash_extra(flash_extra), .win_map(win_map)
  );

  memwait_decode #(.WS_W(WS_W), .CFG_W(CFG_W), .FLASH_BASE(FLASH_BASE),
                   .SLOW_WS(SLOW_WS)) u_dec (
    .addr(req_addr), .write(req_write), .win_map(win_map),
    .flash_extra(flash_extra), .ws(dec_ws), .fault(dec_fault),
    .rd_zero(dec_zero), .tgt_addr(dec_addr)
  );

  memwait_seq #(.WS_W(WS_W), .ADDR_W(AW)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .dec_ws(dec_ws), .dec_fault(dec_fault),
    .dec_zero(dec_zero), .dec_addr(dec_addr), .ready(req_ready),
    .done(acc_done), .wr_stb(acc_wr_stb), .acc_addr(acc_addr),
    .rd_zero(acc_rd_zero), .fault(fault_pulse), .fault_addr(fault_addr)
  );

endmodule

// File: tb/memwait_ctrl_bench.sv
`timescale 1ns/1ps
module memwait_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_ready, acc_done, acc_wr_stb, acc_rd_zero, fault_pulse;
  logic [23:0] acc_addr, fault_addr;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0, cfg_rdata;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  memwait_ctrl u_memwait_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .acc_done(acc_done),
    .acc_wr_stb(acc_wr_stb), .acc_addr(acc_addr), .acc_rd_zero(acc_rd_zero),
    .fault_pulse(fault_pulse), .fault_addr(fault_addr), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  // {req id 4, addr 24, write 1, stall 9, target 24, zero 1, fault 1}
  localparam int NV = 31;
  localparam logic [63:0] VEC [NV] = '{
    {4'd1, 24'h123456, 1'b0, 9'd9,   24'h123456, 1'b0, 1'b0},  // R1
    {4'd2, 24'h123456, 1'b1, 9'd0,   24'h000000, 1'b0, 1'b1},  // R2
    {4'd3, 24'h500000, 1'b0, 9'd257, 24'h500000, 1'b0, 1'b0},  // R3
    {4'd2, 24'h6ABCDE, 1'b1, 9'd0,   24'h000000, 1'b0, 1'b1},  // R2
    {4'd4, 24'h900000, 1'b0, 9'd257, 24'h900000, 1'b0, 1'b0},  // R4
    {4'd4, 24'hC00010, 1'b1, 9'd257, 24'hC00010, 1'b0, 1'b0},  // R4
    {4'd5, 24'hD01234, 1'b0, 9'd3,   24'hD01234, 1'b0, 1'b0},  // R5
    {4'd5, 24'hD01234, 1'b1, 9'd1,   24'hD01234, 1'b0, 1'b0},  // R5
    {4'd5, 24'hD8ABCD, 1'b0, 9'd3,   24'hD0ABCD, 1'b0, 1'b0},  // R5
    {4'd5, 24'hDFFFFF, 1'b1, 9'd1,   24'hD7FFFF, 1'b0, 1'b0},  // R5
    {4'd6, 24'hE0A5C3, 1'b0, 9'd1,   24'hE000C3, 1'b0, 1'b0},  // R6
    {4'd7, 24'hE10040, 1'b0, 9'd1,   24'hE10040, 1'b1, 1'b0},  // R7
    {4'd7, 24'hE10040, 1'b1, 9'd1,   24'hE10040, 1'b0, 1'b0},  // R7
    {4'd6, 24'hE237F1, 1'b0, 9'd3,   24'hE201F1, 1'b0, 1'b0},  // R6
    {4'd6, 24'hE237F1, 1'b1, 9'd3,   24'hE201F1, 1'b0, 1'b0},  // R6
    {4'd6, 24'hE34567, 1'b0, 9'd2,   24'hE34567, 1'b0, 1'b0},  // R6
    {4'd6, 24'hE34567, 1'b1, 9'd1,   24'hE34567, 1'b0, 1'b0},  // R6
    {4'd7, 24'hE80000, 1'b0, 9'd1,   24'hE80000, 1'b1, 1'b0},  // R7
    {4'd8, 24'hF01234, 1'b0, 9'd2,   24'hF00034, 1'b0, 1'b0},  // R8
    {4'd8, 24'hF11234, 1'b1, 9'd2,   24'hF10014, 1'b0, 1'b0},  // R8
    {4'd8, 24'hF2ABCD, 1'b0, 9'd2,   24'hF200CD, 1'b0, 1'b0},  // R8
    {4'd8, 24'hF3ABCD, 1'b0, 9'd2,   24'hF3004D, 1'b0, 1'b0},  // R8
    {4'd8, 24'hF4ABCD, 1'b1, 9'd2,   24'hF40BCD, 1'b0, 1'b0},  // R8
    {4'd8, 24'hF5ABCD, 1'b0, 9'd2,   24'hF5004D, 1'b0, 1'b0},  // R8
    {4'd8, 24'hF6ABCD, 1'b0, 9'd2,   24'hF60BCD, 1'b0, 1'b0},  // R8
    {4'd8, 24'hF7ABCD, 1'b1, 9'd2,   24'hF700CD, 1'b0, 1'b0},  // R8
    {4'd8, 24'hF81FFF, 1'b0, 9'd2,   24'hF8007F, 1'b0, 1'b0},  // R8
    {4'd8, 24'hF90080, 1'b0, 9'd2,   24'hF90000, 1'b0, 1'b0},  // R8
    {4'd7, 24'hFC0000, 1'b0, 9'd2,   24'hFC0000, 1'b1, 1'b0},  // R7
    {4'd7, 24'hFFFFFF, 1'b0, 9'd1,   24'hFFFFFF, 1'b1, 1'b0},  // R7
    {4'd7, 24'hFA0000, 1'b1, 9'd2,   24'hFA0000, 1'b0, 1'b0}   // R7
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Presents one request; returns stall count (cycles req_ready low) and fault flag.
  // On return the bench sits at the negedge showing acc_done (or the fault).
  task automatic access(input logic [23:0] a, input logic w,
                        output int stalls, output logic flt);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    flt = fault_pulse;
    stalls = 0;
    guard = 0;
    if (!flt) begin
      while (!acc_done && guard < 2000) begin
        if (!req_ready) stalls++;
        guard++;
        @(negedge clk);
      end
    end
  endtask

  task automatic run_vec(input int rq, input logic [23:0] a, input logic w,
                         input int ews, input logic [23:0] eaddr,
                         input logic ez, input logic ef);
    int st; logic flt;
    string tg;
    tg = $sformatf("R%0d addr %06h w%0d", rq, a, w);
    access(a, w, st, flt);
    chk(flt == ef, {tg, " fault"}, flt, ef);
    if (ef) begin
      chk(fault_addr == a && req_ready && !acc_done && !acc_wr_stb,
          {tg, " fault side"}, fault_addr, a);
      @(negedge clk);
      chk(!fault_pulse && !acc_done, {tg, " fault one cycle"}, fault_pulse, 0);
    end else begin
      chk(st == ews, {tg, " stall"}, st, ews);
      chk(acc_done && req_ready, {tg, " done"}, acc_done, 1);
      chk(acc_addr == eaddr, {tg, " target"}, acc_addr, eaddr);
      chk(acc_rd_zero == ez, {tg, " zero"}, acc_rd_zero, ez);
      chk(acc_wr_stb == w, {tg, " wstb"}, acc_wr_stb, w);
    end
  endtask

  bit wd_hit = 1'b0;

  initial begin
    #(20 * 200000);
    wd_hit = 1'b1;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int st; logic flt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state (R9, R10)
    chk(req_ready && !acc_done && !fault_pulse && !acc_wr_stb, "R9 reset outputs", req_ready, 1);
    cfg_sel = 1'b0; #1;
    chk(cfg_rdata == 8'd4, "R10 extra reset", cfg_rdata, 4);
    cfg_sel = 1'b1; #1;
    chk(cfg_rdata == 8'd0, "R10 window reset", cfg_rdata, 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(int'(VEC[i][63:60]), VEC[i][59:36], VEC[i][35], int'(VEC[i][34:26]),
              VEC[i][25:2], VEC[i][1], VEC[i][0]);
    end

    // R1: programmable term extremes
    cfg_write(1'b0, 8'd0);
    cfg_sel = 1'b0; #1;
    chk(cfg_rdata == 8'd0, "R10 extra readback", cfg_rdata, 0);
    run_vec(1, 24'h000010, 1'b0, 5, 24'h000010, 1'b0, 1'b0);
    cfg_write(1'b0, 8'd255);
    run_vec(1, 24'h3FFFFF, 1'b0, 260, 24'h3FFFFF, 1'b0, 1'b0);
    cfg_write(1'b0, 8'd4);

    // R3: window bit maps upper region to flash timing, writes still fault
    cfg_write(1'b1, 8'hFF);
    cfg_sel = 1'b1; #1;
    chk(cfg_rdata == 8'd1, "R10 window readback", cfg_rdata, 1);
    run_vec(3, 24'h400000, 1'b0, 9, 24'h400000, 1'b0, 1'b0);
    run_vec(3, 24'h7FFFFF, 1'b1, 0, 24'h0, 1'b0, 1'b1);
    cfg_write(1'b1, 8'h00);
    run_vec(3, 24'h400000, 1'b0, 257, 24'h400000, 1'b0, 1'b0);

    // R10: config write at the same edge as acceptance uses old value
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'd0;
    req_valid = 1'b1; req_addr = 24'h001000; req_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    st = 0;
    while (!acc_done && st < 2000) begin
      if (!req_ready) st++;
      @(negedge clk);
    end
    chk(st == 9, "R10 same-edge old value", st, 9);
    run_vec(10, 24'h001000, 1'b0, 5, 24'h001000, 1'b0, 1'b0);
    cfg_write(1'b0, 8'd4);

    // R9: requests presented during a stall are ignored
    @(negedge clk);
    req_valid = 1'b1; req_addr = 24'hD01234; req_write = 1'b0;
    @(negedge clk);
    req_addr = 24'h900000; req_write = 1'b1;
    st = 0;
    while (!acc_done && st < 2000) begin
      if (!req_ready) st++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(st == 3, "R9 stall with bus held", st, 3);
    chk(acc_addr == 24'hD01234 && !acc_wr_stb, "R9 busy request ignored", acc_addr, 24'hD01234);
    @(negedge clk);
    chk(req_ready && !acc_done, "R9 no extra accept", req_ready, 1);

    // R9: done is one cycle only
    access(24'hE30000, 1'b0, st, flt);
    @(negedge clk);
    chk(!acc_done && req_ready, "R9 done single cycle", acc_done, 0);

    if (!wd_hit) begin
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule